// File: doc/BRIEF.md
# Dynamic Memory Refresh Scheduler

This block keeps the rows of a dynamic memory array alive by issuing periodic row refreshes, and it shares the memory between those refreshes and a host that makes ordinary read and write requests. An interval timer marks when the next refresh falls due. A row counter names the row that comes next. A refresh occupies the memory for a fixed number of cycles, and no column address or data is involved in it. The host side is a plain request/grant handshake. The host raises `host_req`, receives `host_gnt`, and ends its access with a one-cycle `host_done`.

Two scheduling modes are available, and both are chosen while reset is held. In distributed mode, each timer interval adds one owed refresh. Owed refreshes are placed between host accesses. A refresh that falls due during a host access waits until that access ends. It then takes priority over any new host request. The count of postponed refreshes saturates at a small limit. In burst mode, timer intervals add no debt. Instead, once per retention window (ROWS intervals), the block refreshes every row back to back, and the host is locked out for the whole burst. A separate input selects the source of the row address. Either the block drives the row address from its own counter, or it raises a flag that tells the device to use its built-in counter and holds the address bus at zero.

The controller has three states, named `ST_IDLE`, `ST_HOST` and `ST_REF`. These are the transitions:

- IDLE→REF: a refresh is owed.
- IDLE→HOST: no refresh is owed and the host is requesting.
- HOST→IDLE: on `host_done`.
- REF→REF: at the end of a refresh when another refresh is still owed.
- REF→IDLE: at the end of the last owed refresh.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, and directly after it, `host_gnt`, `ref_strobe`, `ref_busy`, `row_src_dev` and `pass_done` are 0 and `ref_row` is 0. The first refreshed row is row 0.
- R2: In distributed mode with no host traffic, the first `ref_strobe` comes INTERVAL+1 cycles after reset release. Later strobes follow exactly INTERVAL cycles apart.
- R3: Each refresh holds `ref_busy` high for exactly REF_CYC cycles. `ref_strobe` is high only in the first of those cycles, and `host_gnt` is low throughout.
- R4: When the block drives the address (`use_dev_ctr`=0), `ref_row` during a refresh equals the row being refreshed. The row advances by one per refresh and returns to 0 after row ROWS-1.
- R5: `pass_done` is high for one cycle, the last busy cycle of the refresh of row ROWS-1, and at no other time.
- R6: A host access that has been granted is never interrupted. `host_gnt` stays high until the cycle after `host_done`, and no refresh starts while it is high.
- R7: The host is granted only when no refresh is owed. After a host access ends with refreshes owed, all of them run before the next grant.
- R8: Owed refreshes run back to back, one `ref_strobe` every REF_CYC cycles. The debt saturates at DEBT_MAX, so a host access longer than DEBT_MAX intervals is followed by exactly DEBT_MAX refreshes.
- R9: In burst mode, no refresh occurs until ROWS intervals have passed. Then ROWS refreshes covering rows 0..ROWS-1 run back to back, starting ROWS*INTERVAL+1 cycles after reset, and the host is not granted until the burst ends.
- R10: With `use_dev_ctr`=1, `row_src_dev` is high exactly while `ref_busy` is high, and `ref_row` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_mode | input | 1 | 1 = burst refresh once per window, 0 = distributed; change only under reset |
| use_dev_ctr | input | 1 | 1 = the device supplies the refresh row, 0 = the block drives it |
| host_req | input | 1 | Host requests the memory |
| host_done | input | 1 | One-cycle pulse that ends the granted host access |
| host_gnt | output | 1 | Host owns the memory |
| ref_strobe | output | 1 | First cycle of a refresh |
| ref_busy | output | 1 | Refresh in progress |
| ref_row | output | $clog2(ROWS) | Row being refreshed (0 when the device counter is used or no refresh is running) |
| row_src_dev | output | 1 | During a refresh, tells the device to use its own row counter |
| pass_done | output | 1 | Pulse marking the end of a full pass over the array |

## Verification
The hardest situation to reach from the ports is debt saturation. It needs a host access that outlasts more than DEBT_MAX timer intervals. The access must also end at a point where no timer interval expires during the refreshes that follow, or the count of refreshes before the next grant becomes ambiguous. The stimulus holds a single grant across eleven intervals and releases it five cycles after an interval boundary. It then counts exactly DEBT_MAX strobes spaced REF_CYC cycles apart before the grant returns. A shorter hold of three intervals checks that the debt is repaid exactly, without saturation.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOST = 2'd1,
        ST_REF  = 2'd2
    } sched_state_t;
endpackage

// File: rtl/ref_timer.sv
module ref_timer #(
    parameter int INTERVAL = 975,
    parameter int ROWS     = 8192
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic win_tick
);
    localparam int TW = $clog2(INTERVAL);
    localparam int WW = $clog2(ROWS);

    logic [TW-1:0] tcnt;
    logic [WW-1:0] wcnt;

    assign tick     = (tcnt == TW'(INTERVAL - 1));
    assign win_tick = tick && (wcnt == WW'(ROWS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
            wcnt <= '0;
        end else begin
            tcnt <= tick ? '0 : tcnt + 1'b1;
            if (tick) wcnt <= win_tick ? '0 : wcnt + 1'b1;
        end
    end

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ref_debt.sv
module ref_debt #(
    parameter int DEBT_MAX = 8,
    localparam int DW = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [DW-1:0] debt
);
    logic [DW:0] sum;

    always_comb begin
        sum = {1'b0, debt} + (DW+1)'(inc) - (DW+1)'(dec);
        if (sum > (DW+1)'(DEBT_MAX)) sum = (DW+1)'(DEBT_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) debt <= '0;
        else               debt <= sum[DW-1:0];
    end

    assert_debt_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DW'(DEBT_MAX));
endmodule

// File: rtl/ref_rowctr.sv
module ref_rowctr #(
    parameter int ROWS = 8192,
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [RW-1:0] row,
    output logic          row_last
);
    assign row_last = (row == RW'(ROWS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (step) row <= row_last ? '0 : row + 1'b1;
    end

    assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (row == (($past(row) == RW'(ROWS - 1)) ? '0 : $past(row) + 1'b1)));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int ROWS     = 8192,
    parameter int INTERVAL = 975,
    parameter int REF_CYC  = 4,
    parameter int DEBT_MAX = 8,
    localparam int ROW_W   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_mode,
    input  logic             use_dev_ctr,
    input  logic             host_req,
    input  logic             host_done,
    output logic             host_gnt,
    output logic             ref_strobe,
    output logic             ref_busy,
    output logic [ROW_W-1:0] ref_row,
    output logic             row_src_dev,
    output logic             pass_done
);
    localparam int CW = $clog2(REF_CYC + 1);
    localparam int BW = ROW_W + 1;
    localparam int DW = $clog2(DEBT_MAX + 1);

    sched_state_t     state, state_nx;
    logic [CW-1:0]    busy_cnt;
    logic [BW-1:0]    burst_left;
    logic [DW-1:0]    debt;
    logic [ROW_W-1:0] row;
    logic             tick, win_tick, row_last, ref_last, due, more;

    ref_timer #(.INTERVAL(INTERVAL), .ROWS(ROWS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .win_tick(win_tick));

    ref_debt #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk(clk), .rst_n(rst_n), .clr(burst_mode),
        .inc(tick && !burst_mode), .dec(ref_last && !burst_mode), .debt(debt));

    ref_rowctr #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .step(ref_last), .row(row), .row_last(row_last));

    assign ref_last = (state == ST_REF) && (busy_cnt == CW'(REF_CYC - 1));
    assign due      = burst_mode ? (burst_left != '0) : (debt != '0);
    assign more     = burst_mode ? (burst_left > BW'(1)) : ((debt > DW'(1)) || tick);

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (due)           state_nx = ST_REF;
                     else if (host_req) state_nx = ST_HOST;
            ST_HOST: if (host_done)     state_nx = ST_IDLE;
            ST_REF:  if (ref_last)      state_nx = more ? ST_REF : ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            busy_cnt   <= '0;
            burst_left <= '0;
        end else begin
            state    <= state_nx;
            busy_cnt <= (state == ST_REF && !ref_last) ? busy_cnt + 1'b1 : '0;
            if (!burst_mode)                         burst_left <= '0;
            else if (win_tick && burst_left == '0)   burst_left <= BW'(ROWS);
            else if (ref_last)                       burst_left <= burst_left - 1'b1;
        end
    end

    // outputs
    always_comb begin
        host_gnt    = (state == ST_HOST);
        ref_busy    = (state == ST_REF);
        ref_strobe  = ref_busy && (busy_cnt == '0);
        ref_row     = (ref_busy && !use_dev_ctr) ? row : '0;
        row_src_dev = ref_busy && use_dev_ctr;
        pass_done   = ref_last && row_last;
    end

    assert_strobe_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_busy) |-> ref_strobe);
    assert_host_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && !host_done) |=> host_gnt);
    assert_gnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_gnt) |-> ($past(debt) == '0 && $past(burst_left) == '0));
    assert_dev_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
        row_src_dev |-> (ref_row == '0));
    assert_pass_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);
endmodule

// File: tb/refresh_sched_tb_top.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;
    localparam int ROWS = 8, INTERVAL = 40, REF_CYC = 3, DEBT_MAX = 8;
    localparam int RW = $clog2(ROWS);

    logic clk = 1'b0, rst_n = 1'b0;
    logic burst_mode = 1'b0, use_dev_ctr = 1'b0, host_req = 1'b0, host_done = 1'b0;
    logic host_gnt, ref_strobe, ref_busy, row_src_dev, pass_done;
    logic [RW-1:0] ref_row;

    int checks = 0, fails = 0, cyc = 0, scnt = 0, pcnt = 0, ovl = 0;
    int stamp [32];
    int rowlog [32];

    always #4 clk = ~clk;

    refresh_sched #(.ROWS(ROWS), .INTERVAL(INTERVAL), .REF_CYC(REF_CYC), .DEBT_MAX(DEBT_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .use_dev_ctr(use_dev_ctr),
        .host_req(host_req), .host_done(host_done), .host_gnt(host_gnt),
        .ref_strobe(ref_strobe), .ref_busy(ref_busy), .ref_row(ref_row),
        .row_src_dev(row_src_dev), .pass_done(pass_done));

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            scnt <= 0; pcnt <= 0; ovl <= 0;
        end else begin
            if (ref_strobe) begin
                if (scnt < 32) begin
                    stamp[scnt]  <= cyc;
                    rowlog[scnt] <= int'(ref_row);
                end
                scnt <= scnt + 1;
            end
            if (pass_done) pcnt <= pcnt + 1;
            if (host_gnt && ref_busy) ovl <= ovl + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset(input logic bm, input logic dev);
        @(negedge clk);
        rst_n = 1'b0; host_req = 1'b0; host_done = 1'b0;
        burst_mode = bm; use_dev_ctr = dev;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk("R1 outputs in reset", int'({host_gnt, ref_strobe, ref_busy, row_src_dev, pass_done}) + int'(ref_row), 0);
        rst_n = 1'b1;
    endtask

    task automatic pulse_done;
        host_done = 1'b1;
        @(negedge clk);
        host_done = 1'b0;
    endtask

    task automatic t_distributed;
        do_reset(1'b0, 1'b0);
        wait_to(40);
        chk("R2 no refresh before interval", int'(ref_busy), 0);
        wait_to(41);
        chk("R3 strobe at first busy cycle", int'(ref_strobe && ref_busy), 1);
        chk("R1 first row is zero", int'(ref_row), 0);
        wait_to(43);
        chk("R3 busy, no strobe in last cycle", int'(ref_busy && !ref_strobe), 1);
        wait_to(44);
        chk("R3 busy ends after REF_CYC", int'(ref_busy), 0);
        wait_to(322);
        chk("R5 no pass before last row ends", int'(pass_done), 0);
        wait_to(323);
        chk("R5 pass pulse on last cycle of last row", int'(pass_done), 1);
        wait_to(400);
        chk("R2 refresh count", scnt, 9);
        chk("R2 first strobe cycle", stamp[0], INTERVAL + 1);
        for (int i = 1; i < 9; i++) chk("R2 strobe spacing", stamp[i] - stamp[i-1], INTERVAL);
        for (int i = 0; i < 9; i++) chk("R4 row order with wrap", rowlog[i], i % ROWS);
        chk("R5 one pass pulse", pcnt, 1);
    endtask

    task automatic t_host_debt;
        do_reset(1'b0, 1'b0);
        wait_to(5);
        host_req = 1'b1;
        wait_to(6);
        chk("R7 grant with no debt", int'(host_gnt), 1);
        wait_to(130);
        chk("R6 grant held across ticks", int'(host_gnt), 1);
        chk("R6 no refresh during access", scnt, 0);
        pulse_done;
        wait_to(141);
        chk("R7 no grant while refreshes owed", int'(host_gnt), 0);
        chk("R8 owed refreshes repaid", scnt, 3);
        chk("R8 first repay strobe", stamp[0], 132);
        chk("R8 back-to-back spacing", stamp[2] - stamp[1], REF_CYC);
        wait_to(142);
        chk("R7 grant after debt cleared", int'(host_gnt), 1);
        chk("R3 no grant during refresh", ovl, 0);
        pulse_done;
        host_req = 1'b0;
    endtask

    task automatic t_debt_cap;
        do_reset(1'b0, 1'b0);
        wait_to(5);
        host_req = 1'b1;
        wait_to(445);
        chk("R6 long access not interrupted", scnt, 0);
        pulse_done;
        wait_to(471);
        chk("R8 debt saturates at limit", scnt, DEBT_MAX);
        chk("R8 last capped strobe", stamp[DEBT_MAX-1], 447 + (DEBT_MAX - 1) * REF_CYC);
        chk("R7 no grant before debt cleared", int'(host_gnt), 0);
        wait_to(472);
        chk("R7 grant after capped debt", int'(host_gnt), 1);
        pulse_done;
        host_req = 1'b0;
    endtask

    task automatic t_burst;
        do_reset(1'b1, 1'b0);
        wait_to(320);
        chk("R9 no refresh before window", scnt, 0);
        wait_to(322);
        host_req = 1'b1;
        wait_to(345);
        chk("R9 host locked out during burst", int'(host_gnt), 0);
        chk("R9 burst covers all rows", scnt, ROWS);
        chk("R9 burst start cycle", stamp[0], ROWS * INTERVAL + 1);
        chk("R9 burst back-to-back", stamp[ROWS-1] - stamp[0], (ROWS - 1) * REF_CYC);
        for (int i = 0; i < ROWS; i++) chk("R9 burst row order", rowlog[i], i);
        chk("R5 pass at burst end", pcnt, 1);
        wait_to(346);
        chk("R9 grant after burst", int'(host_gnt), 1);
        pulse_done;
        host_req = 1'b0;
    endtask

    task automatic t_devctr;
        do_reset(1'b0, 1'b1);
        wait_to(41);
        chk("R10 device flag during refresh", int'(row_src_dev && ref_busy), 1);
        wait_to(44);
        chk("R10 device flag drops with busy", int'(row_src_dev), 0);
        wait_to(82);
        chk("R10 row bus held at zero", int'(ref_row), 0);
        chk("R10 flag tracks busy", int'(row_src_dev), int'(ref_busy));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_distributed();
        t_host_debt();
        t_debt_cap();
        t_burst();
        t_devctr();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule